// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line). It lets a bus master reach a byte-wide register file through a 16-bit register pointer. Both bus lines are oversampled by a fast system clock through two-flop synchronizers. Start, repeated start and stop conditions are recognised from the sampled waveforms.

A transfer opens with an address byte. A strap input picks which of two device addresses the block answers to. In a write, two pointer bytes and then any number of data bytes follow. Each data byte leaves the block on a one-cycle write strobe, and the pointer then steps. A read is begun with a repeated start after the pointer has been loaded. The block then shifts register bytes out MSB first until the master declines one.

The register file sits outside the block. It is reached through a write port and through a combinational read port addressed by the current pointer.

Top module: `twi_reg_slave`

## Requirements
- R1: With `addr_sel_i` low, the block acknowledges the address byte 0x90 (write) and 0x91 (read), where bits [7:1] are the device address and bit [0] is the direction, 1 meaning read.
- R2: With `addr_sel_i` high, the block acknowledges 0xBA (write) and 0xBB (read), and does not acknowledge 0x91.
- R3: After an address byte that does not match, the block never pulls SDA low until the next start condition, and none of the following bytes is acknowledged or written.
- R4: In a write, the two bytes after the address byte are acknowledged and load the pointer, high byte first.
- R5: Each later write byte is acknowledged. It produces one `wr_en_o` pulse carrying the current pointer and the byte, and the pointer then increments by one.
- R6: In a read, the block drives the byte at the pointer MSB first, one bit per SCL period. The pointer increments after every byte sent.
- R7: When the master returns a no-acknowledge (SDA high in the ninth period) after a read byte, the block releases SDA and stays released until the next start.
- R8: A repeated start ends a write sequence, and the pointer loaded before it is kept for the read that follows.
- R9: A start or stop in the middle of a byte aborts that byte: no write strobe occurs and the pointer does not change.
- R10: The block changes its SDA pull-down only while SCL is low, and a stop always leaves SDA released.
- R11: After reset, SDA is released, no write strobe is active, and the pointer is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe_o | output | 1 | When 1, pulls the data line low |
| addr_sel_i | input | 1 | Strap selecting one of two device addresses |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 16 | Register address for the write |
| wr_data_o | output | 8 | Register data for the write |
| rd_addr_o | output | 16 | Current register pointer, used as the read address |
| rd_data_i | input | 8 | Register contents at `rd_addr_o` |

## Verification
Some rules hold on every cycle, and the assertions check them there. The pull-down never moves while the synchronized SCL is high, except on a start or stop. A stop is always followed by a released line, and the skip state never drives. A write strobe only comes out of the data-byte state, with the pointer one past the written address.

Other behaviour can only be shown by driving whole bus transactions from the bench. This covers address matching under both strap values, pointer loading and retention across a repeated start, MSB-first read data, and the ending of a read by a no-acknowledge. It also covers the aborted partial byte, which must leave the pointer unchanged and produce no write.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_PHI, ST_PLO, ST_WDAT, ST_RDAT, ST_SKIP
  } twi_state_e;

  // device address compare on bits [7:1] of the first byte
  function automatic logic addr_hit(input logic [7:0] b, input logic sel,
                                    input logic [6:0] lo, input logic [6:0] hi);
    return b[7:1] == (sel ? hi : lo);
  endfunction

  function automatic logic [15:0] ptr_step(input logic [15:0] p);
    return p + 16'd1;
  endfunction
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES-1:0] pipe;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[0] <= 1'b1;
          else        pipe[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[g] <= 1'b1;
          else        pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q_prev <= 1'b1;
    else        q_prev <= pipe[STAGES-1];

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic scl_s,
  input  logic scl_q,
  input  logic sda_s,
  input  logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_ctrl.sv
module twi_ctrl
  import twi_pkg::*;
#(
  parameter int       PTR_W   = 16,
  parameter int       DATA_W  = 8,
  parameter logic [6:0] DEV_LO = 7'h48,
  parameter logic [6:0] DEV_HI = 7'h5D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [PTR_W-1:0]  ptr,
  output twi_state_e        state,
  output logic              ack_slot
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bitn;
  logic              rw;
  logic              m_ack;
  logic              active;
  logic              go_read;

  assign active  = (state != ST_IDLE) && (state != ST_SKIP);
  assign go_read = ((state == ST_DEV) && rw) || ((state == ST_RDAT) && m_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitn     <= '0;
      ack_slot <= 1'b0;
      sda_oe   <= 1'b0;
      shreg    <= '0;
      rw       <= 1'b0;
      m_ack    <= 1'b0;
      ptr      <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= ST_DEV;
        bitn     <= '0;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        bitn     <= '0;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (ack_slot)              m_ack <= ~sda_s;
          else if (state == ST_RDAT) bitn  <= bitn + 1'b1;
          else begin
            shreg <= {shreg[DATA_W-2:0], sda_s};
            bitn  <= bitn + 1'b1;
          end
        end else if (scl_fall) begin
          if (ack_slot) begin
            ack_slot <= 1'b0;
            bitn     <= '0;
            sda_oe   <= 1'b0;
            case (state)
              ST_DEV:  state <= rw ? ST_RDAT : ST_PHI;
              ST_PHI:  state <= ST_PLO;
              ST_PLO:  state <= ST_WDAT;
              ST_RDAT: if (!m_ack) state <= ST_SKIP;
              default: state <= state;
            endcase
            if (go_read) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[DATA_W-1];
            end
          end else if (bitn == LAST) begin
            ack_slot <= 1'b1;
            case (state)
              ST_DEV: begin
                if (addr_hit(shreg, addr_sel, DEV_LO, DEV_HI)) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                end else begin
                  state    <= ST_SKIP;
                  ack_slot <= 1'b0;
                end
              end
              ST_PHI: begin
                ptr[PTR_W-1:PTR_W-8] <= shreg;
                sda_oe <= 1'b1;
              end
              ST_PLO: begin
                ptr[7:0] <= shreg;
                sda_oe   <= 1'b1;
              end
              ST_WDAT: begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                ptr     <= ptr_step(ptr);
                sda_oe  <= 1'b1;
              end
              ST_RDAT: begin
                sda_oe <= 1'b0;
                ptr    <= ptr_step(ptr);
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (state == ST_RDAT) begin
            shreg  <= {shreg[DATA_W-2:0], 1'b0};
            sda_oe <= ~shreg[DATA_W-2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_pkg::*;
#(
  parameter int         PTR_W   = 16,
  parameter int         DATA_W  = 8,
  parameter int         SYNC_N  = 2,
  parameter logic [6:0] DEV_LO  = 7'h48,
  parameter logic [6:0] DEV_HI  = 7'h5D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              addr_sel_i,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [PTR_W-1:0]  rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  logic scl_s, scl_q, sda_s, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic ack_slot;
  logic in_skip, in_wdat;
  twi_state_e state;

  twi_line_sync #(.STAGES(SYNC_N)) u_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s), .q_prev(scl_q));
  twi_line_sync #(.STAGES(SYNC_N)) u_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s), .q_prev(sda_q));

  twi_cond_detect u_cond (
    .scl_s(scl_s), .scl_q(scl_q), .sda_s(sda_s), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  twi_ctrl #(.PTR_W(PTR_W), .DATA_W(DATA_W), .DEV_LO(DEV_LO), .DEV_HI(DEV_HI)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data_i), .sda_oe(sda_oe_o),
    .wr_en(wr_en_o), .wr_addr(wr_addr_o), .wr_data(wr_data_o),
    .ptr(rd_addr_o), .state(state), .ack_slot(ack_slot));

  assign in_skip = (state == ST_SKIP);
  assign in_wdat = (state == ST_WDAT);
endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk #(
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_oe,
  input logic             wr_en,
  input logic [PTR_W-1:0] wr_addr,
  input logic [PTR_W-1:0] ptr,
  input logic             in_skip,
  input logic             in_wdat
);
  // R10: pull-down moves only with SCL low, unless a bus condition reset it
  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

  // R10: a stop leaves the line released
  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R3 and R7: skip state never drives the line
  assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_skip |-> !sda_oe);

  // R5: strobes come only from the data-byte state
  assert_wr_from_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(in_wdat));

  // R5: pointer has stepped past the written address
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr == wr_addr + 1'b1));
endmodule

bind twi_reg_slave twi_reg_slave_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe_o), .wr_en(wr_en_o),
  .wr_addr(wr_addr_o), .ptr(rd_addr_o), .in_skip(in_skip), .in_wdat(in_wdat));

// File: tb/sim_twi_reg_slave.sv
`timescale 1ns/1ps
module sim_twi_reg_slave;
  localparam int T = 8;  // clocks per quarter SCL period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sel = 1'b0;
  logic sda_oe, wr_en;
  logic [15:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic sda_bus;

  int n_chk = 0, n_fail = 0, cyc = 0, viol = 0;
  logic [23:0] exp_wr[$];
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign sda_bus = m_sda & ~sda_oe;
  assign rd_data = mem_val(rd_addr);

  twi_reg_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_sel_i(sel), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    check(viol == 0, "R10", "pull-down moved with SCL high", viol, 0);
    check(exp_wr.size() == 0, "R9", "writes still expected", exp_wr.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // per-clock reference comparison: write port and line discipline
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (m_scl && prev_scl && sda_oe != prev_oe) viol++;
      if (wr_en) begin
        if (exp_wr.size() == 0)
          check(0, "R9", "unexpected write", {wr_addr, wr_data}, 0);
        else begin
          logic [23:0] e;
          e = exp_wr.pop_front();
          check({wr_addr, wr_data} == e, "R5", "write addr/data", {wr_addr, wr_data}, e);
        end
      end
    end
    prev_scl = m_scl;
    prev_oe  = sda_oe;
    if (cyc > 150000) begin
      check(0, "watchdog", "run did not finish", cyc, 0);
      finish_run();
    end
  end

  task automatic wait_q(); repeat (T) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_q(); m_scl = 1'b1; wait_q();
    m_sda = 1'b0; wait_q(); m_scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_q(); m_scl = 1'b1; wait_q(); m_sda = 1'b1; wait_q();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wait_q(); m_scl = 1'b1; wait_q(); wait_q(); m_scl = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wait_q(); m_scl = 1'b1; wait_q();
    ack = ~sda_bus; wait_q(); m_scl = 1'b0; wait_q();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      m_sda = 1'b1; wait_q(); m_scl = 1'b1; wait_q();
      d = {d[6:0], sda_bus}; wait_q(); m_scl = 1'b0; wait_q();
    end
    send_bit(~mack);
    m_sda = 1'b1;
  endtask

  logic ack;
  logic [7:0] d;

  initial begin
    repeat (4) @(negedge clk);
    check(sda_oe == 1'b0, "R11", "oe after reset", sda_oe, 0);
    check(wr_en == 1'b0, "R11", "wr_en after reset", wr_en, 0);
    check(rd_addr == 16'h0, "R11", "pointer after reset", rd_addr, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // strap low: write two bytes
    sel = 1'b0;
    bus_start();
    send_byte(8'h90, ack); check(ack, "R1", "ack 0x90", ack, 1);
    send_byte(8'h12, ack); check(ack, "R4", "ack ptr hi", ack, 1);
    send_byte(8'h34, ack); check(ack, "R4", "ack ptr lo", ack, 1);
    exp_wr.push_back({16'h1234, 8'hA1});
    send_byte(8'hA1, ack); check(ack, "R5", "ack data 0", ack, 1);
    exp_wr.push_back({16'h1235, 8'h5C});
    send_byte(8'h5C, ack); check(ack, "R5", "ack data 1", ack, 1);
    bus_stop();
    check(rd_addr == 16'h1236, "R5", "pointer after two writes", rd_addr, 16'h1236);
    check(sda_oe == 1'b0, "R10", "released after stop", sda_oe, 0);

    // strap low: read-low address acknowledged
    bus_start();
    send_byte(8'h91, ack); check(ack, "R1", "ack 0x91", ack, 1);
    recv_byte(1'b0, d);
    check(d == mem_val(16'h1236), "R6", "read at pointer", d, mem_val(16'h1236));
    bus_stop();

    // strap low: other address ignored
    bus_start();
    send_byte(8'hBA, ack); check(!ack, "R3", "no ack for 0xBA", ack, 0);
    send_byte(8'h00, ack); check(!ack, "R3", "no ack after mismatch", ack, 0);
    send_byte(8'h77, ack); check(!ack, "R3", "no ack second byte", ack, 0);
    bus_stop();
    check(rd_addr == 16'h1237, "R3", "pointer untouched by ignored bytes", rd_addr, 16'h1237);

    // strap high: write then repeated start and burst read
    sel = 1'b1;
    bus_start();
    send_byte(8'hBA, ack); check(ack, "R2", "ack 0xBA", ack, 1);
    send_byte(8'h00, ack); check(ack, "R4", "ack ptr hi", ack, 1);
    send_byte(8'hFF, ack); check(ack, "R4", "ack ptr lo", ack, 1);
    exp_wr.push_back({16'h00FF, 8'h3C});
    send_byte(8'h3C, ack); check(ack, "R5", "ack data", ack, 1);
    bus_start();
    send_byte(8'hBB, ack); check(ack, "R8", "ack 0xBB after restart", ack, 1);
    recv_byte(1'b1, d);
    check(d == mem_val(16'h0100), "R6", "read byte 0", d, mem_val(16'h0100));
    recv_byte(1'b0, d);
    check(d == mem_val(16'h0101), "R6", "read byte 1", d, mem_val(16'h0101));
    repeat (4) @(negedge clk);
    check(sda_oe == 1'b0, "R7", "released after nack", sda_oe, 0);
    check(rd_addr == 16'h0102, "R6", "pointer after two reads", rd_addr, 16'h0102);
    send_byte(8'hFF, ack); check(!ack, "R7", "quiet after nack", ack, 0);
    bus_stop();

    bus_start();
    send_byte(8'h91, ack); check(!ack, "R2", "no ack 0x91 strap high", ack, 0);
    bus_stop();

    // abort by stop mid-byte
    bus_start();
    send_byte(8'hBA, ack);
    send_byte(8'h20, ack);
    send_byte(8'h00, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    check(rd_addr == 16'h2000, "R9", "pointer after stop abort", rd_addr, 16'h2000);

    // abort by restart mid-byte, pointer kept for read
    bus_start();
    send_byte(8'hBA, ack);
    send_byte(8'h20, ack);
    send_byte(8'h10, ack);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_start();
    send_byte(8'hBB, ack); check(ack, "R8", "ack read after abort", ack, 1);
    recv_byte(1'b0, d);
    check(d == mem_val(16'h2010), "R9", "read at kept pointer", d, mem_val(16'h2010));
    bus_stop();
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule